// File: doc/BRIEF.md
# Descriptor Table Register Unit

This unit keeps the four registers that locate the segmentation tables of a processor core: the global table register and the interrupt table register (each a base address and a byte-count limit), and the local-table register and the task register (each a selector plus a cached copy of the base, limit and attribute fields taken from the descriptor that the selector names). The cached registers drive the segmentation logic directly through plain outputs.

Commands arrive on one valid/ready stream. The two table-only registers are loaded and read back as a whole. The two selector-based registers are loaded with a selector only. The unit checks that the selector's slot lies inside the global table, fetches the 8-byte slot over a request/response memory port, and fills the cached fields from the returned descriptor. A task-switch command writes selector and descriptor into both selector-based registers at once. Earlier contents are overwritten and never saved. Read-back values leave on a second valid/ready stream. A result is held until `st_ready` is high, and no new command is taken while a result is waiting. The memory request holds its address until `mem_req_ready` is high. The response has no ready and is always taken while a fetch waits.

Top module: `dtr_unit`

## Requirements
- R1: After reset every base and every selector reads 0, every limit reads 16'hFFFF, both attribute fields read 0, `ldt_valid` is 0, `busy` and `fault` are 0, and `cmd_ready` is 1.
- R2: Op 0 loads `cmd_base`/`cmd_limit` into the global table register and op 1 loads them into the interrupt table register. The new values are visible on the outputs in the cycle after acceptance.
- R3: Ops 2, 3, 6 and 7 return the global table register, the interrupt table register, the local-table selector and the task selector on `st_base`, `st_limit` and `st_sel`. The unused fields read 0. `st_valid` rises the cycle after acceptance, the data holds steady until `st_ready` is sampled high, and `cmd_ready` is 0 while a result waits.
- R4: Op 4 (local table) and op 5 (task) issue a memory request with `mem_addr` = global base + selector[15:3]*8. Request and address hold until `mem_req_ready` is sampled high.
- R5: A response word is split as base = bits [31:0], limit = bits [47:32] and attributes = bits [55:48]. These fields and the selector are written to the target register in the cycle after `mem_rsp_valid`. A local-table fill sets `ldt_valid`. Until then the target keeps its old contents.
- R6: If {selector[15:3], 3'b111} exceeds the global limit, no request is made, the target register is unchanged, and `fault` is high for exactly the one cycle after acceptance.
- R7: `busy` is high from the cycle after a fetching load is accepted until the descriptor has been written. While busy, `cmd_ready` is 0 and offered commands have no effect.
- R8: Op 4 with selector[15:3] = 0 makes no memory request. It writes the selector, clears `ldt_valid`, and leaves the cached base, limit and attributes unchanged.
- R9: Op 8 (task switch) writes `cmd_sel`/`cmd_desc` into the task register and `cmd_aux_sel`/`cmd_aux_desc` into the local-table register in the cycle after acceptance, with no fetch. `ldt_valid` becomes 1 unless `cmd_aux_sel`[15:3] is 0.
- R10: Op codes 9 to 15 are accepted and change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 4 | Command code |
| cmd_base | input | BASE_W | Base for table loads |
| cmd_limit | input | LIM_W | Limit for table loads |
| cmd_sel | input | SEL_W | Selector for selector loads and task-switch task selector |
| cmd_desc | input | DESC_W | Task-switch task descriptor |
| cmd_aux_sel | input | SEL_W | Task-switch local-table selector |
| cmd_aux_desc | input | DESC_W | Task-switch local-table descriptor |
| st_valid | output | 1 | Read-back result waiting |
| st_ready | input | 1 | Read-back result taken |
| st_base | output | BASE_W | Read-back base |
| st_limit | output | LIM_W | Read-back limit |
| st_sel | output | SEL_W | Read-back selector |
| mem_req_valid | output | 1 | Descriptor fetch request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_addr | output | BASE_W | Linear address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | DESC_W | Descriptor word |
| busy | output | 1 | Fetch in progress |
| fault | output | 1 | Selector outside global table |
| gdt_base | output | BASE_W | Global table base |
| gdt_limit | output | LIM_W | Global table limit |
| idt_base | output | BASE_W | Interrupt table base |
| idt_limit | output | LIM_W | Interrupt table limit |
| ldt_sel | output | SEL_W | Local-table selector |
| ldt_base | output | BASE_W | Cached local-table base |
| ldt_limit | output | LIM_W | Cached local-table limit |
| ldt_attr | output | ATTR_W | Cached local-table attributes |
| ldt_valid | output | 1 | Cached local-table descriptor usable |
| tr_sel | output | SEL_W | Task selector |
| tr_base | output | BASE_W | Cached task-state base |
| tr_limit | output | LIM_W | Cached task-state limit |
| tr_attr | output | ATTR_W | Cached task-state attributes |

## Verification
The assertions assume the memory side returns exactly one response per accepted request, never while no fetch is waiting. They also assume `mem_rsp_valid` is not raised in the same cycle the request is taken. The bench's memory model meets this by answering each accepted request one cycle later and staying quiet otherwise, and it can withhold `mem_req_ready` to test request hold. The read-back holding property relies on the consumer only ever raising `st_ready` on its own, and the bench keeps it low except for single acceptance cycles.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [3:0] {
    OP_LD_GTAB = 4'd0,
    OP_LD_ITAB = 4'd1,
    OP_ST_GTAB = 4'd2,
    OP_ST_ITAB = 4'd3,
    OP_LD_LSEL = 4'd4,
    OP_LD_TSEL = 4'd5,
    OP_ST_LSEL = 4'd6,
    OP_ST_TSEL = 4'd7,
    OP_TSWITCH = 4'd8
  } dtr_op_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_e;

  // target of a descriptor fetch
  localparam logic TGT_LOCAL = 1'b0;
  localparam logic TGT_TASK  = 1'b1;

endpackage

// File: rtl/dtr_table_reg.sv
module dtr_table_reg #(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BASE_W-1:0] base_in,
  input  logic [LIM_W-1:0]  lim_in,
  output logic [BASE_W-1:0] base_q,
  output logic [LIM_W-1:0]  lim_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '1;
    end else if (we) begin
      base_q <= base_in;
      lim_q  <= lim_in;
    end
  end

endmodule

// File: rtl/dtr_seg_reg.sv
module dtr_seg_reg #(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ATTR_W = 8,
  localparam int DESC_W = BASE_W + LIM_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic              ld_valid,
  input  logic              nul_en,
  input  logic [SEL_W-1:0]  nul_sel,
  output logic [SEL_W-1:0]  sel_q,
  output logic [BASE_W-1:0] base_q,
  output logic [LIM_W-1:0]  lim_q,
  output logic [ATTR_W-1:0] attr_q,
  output logic              valid_q
);

  logic [BASE_W-1:0] d_base;
  logic [LIM_W-1:0]  d_lim;
  logic [ATTR_W-1:0] d_attr;

  // descriptor word: base low, limit above it, attributes on top
  assign d_base = ld_desc[BASE_W-1:0];
  assign d_lim  = ld_desc[BASE_W+LIM_W-1:BASE_W];
  assign d_attr = ld_desc[DESC_W-1:BASE_W+LIM_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      base_q  <= '0;
      lim_q   <= '1;
      attr_q  <= '0;
      valid_q <= 1'b0;
    end else if (ld_en) begin
      sel_q   <= ld_sel;
      base_q  <= d_base;
      lim_q   <= d_lim;
      attr_q  <= d_attr;
      valid_q <= ld_valid;
    end else if (nul_en) begin
      sel_q   <= nul_sel;
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dtr_fetch.sv
module dtr_fetch
  import dtr_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ATTR_W = 8,
  localparam int DESC_W = BASE_W + LIM_W + ATTR_W,
  localparam int CMP_W  = (SEL_W > LIM_W) ? SEL_W : LIM_W,
  localparam int IDX_W  = SEL_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_tgt,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic [BASE_W-1:0] tab_base,
  input  logic [LIM_W-1:0]  tab_limit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [BASE_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              wr_en,
  output logic              wr_tgt,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DESC_W-1:0] wr_desc,
  output logic              busy,
  output logic              fault
);

  fetch_state_e      state_q;
  logic              tgt_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BASE_W-1:0] addr_q;
  logic              fault_q;
  logic [IDX_W-1:0]  idx;
  logic [CMP_W-1:0]  slot_end;
  logic              out_of_table;
  logic [BASE_W-1:0] slot_off;

  assign idx          = start_sel[SEL_W-1:3];
  assign slot_end     = CMP_W'({idx, 3'b111});
  assign out_of_table = slot_end > CMP_W'(tab_limit);
  assign slot_off     = BASE_W'({idx, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      tgt_q   <= TGT_LOCAL;
      sel_q   <= '0;
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (state_q)
        FS_IDLE: begin
          if (start) begin
            if (out_of_table) begin
              fault_q <= 1'b1;
            end else begin
              state_q <= FS_REQ;
              tgt_q   <= start_tgt;
              sel_q   <= start_sel;
              addr_q  <= tab_base + slot_off;
            end
          end
        end
        FS_REQ: begin
          if (mem_req_ready) state_q <= FS_WAIT;
        end
        FS_WAIT: begin
          if (mem_rsp_valid) state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_addr      = addr_q;
  assign wr_en         = (state_q == FS_WAIT) && mem_rsp_valid;
  assign wr_tgt        = tgt_q;
  assign wr_sel        = sel_q;
  assign wr_desc       = mem_rsp_data;
  assign busy          = (state_q != FS_IDLE);
  assign fault         = fault_q;

endmodule

// File: rtl/dtr_unit.sv
module dtr_unit
  import dtr_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ATTR_W = 8,
  localparam int DESC_W = BASE_W + LIM_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [BASE_W-1:0] cmd_base,
  input  logic [LIM_W-1:0]  cmd_limit,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [DESC_W-1:0] cmd_desc,
  input  logic [SEL_W-1:0]  cmd_aux_sel,
  input  logic [DESC_W-1:0] cmd_aux_desc,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [BASE_W-1:0] st_base,
  output logic [LIM_W-1:0]  st_limit,
  output logic [SEL_W-1:0]  st_sel,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [BASE_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              fault,
  output logic [BASE_W-1:0] gdt_base,
  output logic [LIM_W-1:0]  gdt_limit,
  output logic [BASE_W-1:0] idt_base,
  output logic [LIM_W-1:0]  idt_limit,
  output logic [SEL_W-1:0]  ldt_sel,
  output logic [BASE_W-1:0] ldt_base,
  output logic [LIM_W-1:0]  ldt_limit,
  output logic [ATTR_W-1:0] ldt_attr,
  output logic              ldt_valid,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [BASE_W-1:0] tr_base,
  output logic [LIM_W-1:0]  tr_limit,
  output logic [ATTR_W-1:0] tr_attr
);

  localparam int NTAB = 2;
  localparam int NSEG = 2;

  dtr_op_e op;
  logic    take;
  logic    fetch_busy;

  assign op        = dtr_op_e'(cmd_op);
  assign cmd_ready = !fetch_busy && !st_valid;
  assign take      = cmd_valid && cmd_ready;
  assign busy      = fetch_busy;

  // ---- table-only registers (index 0: global, 1: interrupt) ----
  logic [BASE_W-1:0] tab_base [NTAB];
  logic [LIM_W-1:0]  tab_lim  [NTAB];

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    logic we_t;
    assign we_t = take && (op == ((t == 0) ? OP_LD_GTAB : OP_LD_ITAB));
    dtr_table_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .we(we_t),
      .base_in(cmd_base), .lim_in(cmd_limit),
      .base_q(tab_base[t]), .lim_q(tab_lim[t])
    );
  end

  assign gdt_base  = tab_base[0];
  assign gdt_limit = tab_lim[0];
  assign idt_base  = tab_base[1];
  assign idt_limit = tab_lim[1];

  // ---- descriptor fetch engine ----
  logic              fetch_start;
  logic              fetch_tgt;
  logic              sel_null;
  logic              wr_en;
  logic              wr_tgt;
  logic [SEL_W-1:0]  wr_sel;
  logic [DESC_W-1:0] wr_desc;

  assign sel_null    = (cmd_sel[SEL_W-1:3] == '0);
  assign fetch_tgt   = (op == OP_LD_TSEL) ? TGT_TASK : TGT_LOCAL;
  assign fetch_start = take && ((op == OP_LD_TSEL) || (op == OP_LD_LSEL && !sel_null));

  dtr_fetch #(.BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .ATTR_W(ATTR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(fetch_start), .start_tgt(fetch_tgt), .start_sel(cmd_sel),
    .tab_base(tab_base[0]), .tab_limit(tab_lim[0]),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_sel(wr_sel), .wr_desc(wr_desc),
    .busy(fetch_busy), .fault(fault)
  );

  // ---- selector-based registers (index 0: local table, 1: task) ----
  logic              is_switch;
  logic [SEL_W-1:0]  seg_sel   [NSEG];
  logic [BASE_W-1:0] seg_base  [NSEG];
  logic [LIM_W-1:0]  seg_lim   [NSEG];
  logic [ATTR_W-1:0] seg_attr  [NSEG];
  logic              seg_valid [NSEG];

  assign is_switch = take && (op == OP_TSWITCH);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic              fill_s;
    logic              ld_s;
    logic [SEL_W-1:0]  lsel_s;
    logic [DESC_W-1:0] ldesc_s;
    logic              lvalid_s;
    logic              nul_s;
    logic [SEL_W-1:0]  sw_sel;
    logic [DESC_W-1:0] sw_desc;

    assign sw_sel   = (s == 0) ? cmd_aux_sel  : cmd_sel;
    assign sw_desc  = (s == 0) ? cmd_aux_desc : cmd_desc;
    assign fill_s   = wr_en && (wr_tgt == ((s == 0) ? TGT_LOCAL : TGT_TASK));
    assign ld_s     = fill_s || is_switch;
    assign lsel_s   = fill_s ? wr_sel  : sw_sel;
    assign ldesc_s  = fill_s ? wr_desc : sw_desc;
    assign lvalid_s = fill_s || (sw_sel[SEL_W-1:3] != '0);
    assign nul_s    = (s == 0) && take && (op == OP_LD_LSEL) && sel_null;

    dtr_seg_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .ATTR_W(ATTR_W)) u_seg (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_s), .ld_sel(lsel_s), .ld_desc(ldesc_s), .ld_valid(lvalid_s),
      .nul_en(nul_s), .nul_sel(cmd_sel),
      .sel_q(seg_sel[s]), .base_q(seg_base[s]), .lim_q(seg_lim[s]),
      .attr_q(seg_attr[s]), .valid_q(seg_valid[s])
    );
  end

  assign ldt_sel   = seg_sel[0];
  assign ldt_base  = seg_base[0];
  assign ldt_limit = seg_lim[0];
  assign ldt_attr  = seg_attr[0];
  assign ldt_valid = seg_valid[0];
  assign tr_sel    = seg_sel[1];
  assign tr_base   = seg_base[1];
  assign tr_limit  = seg_lim[1];
  assign tr_attr   = seg_attr[1];

  // ---- read-back stream ----
  logic              st_valid_q;
  logic [BASE_W-1:0] st_base_q;
  logic [LIM_W-1:0]  st_lim_q;
  logic [SEL_W-1:0]  st_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_base_q  <= '0;
      st_lim_q   <= '0;
      st_sel_q   <= '0;
    end else if (take) begin
      st_base_q <= '0;
      st_lim_q  <= '0;
      st_sel_q  <= '0;
      case (op)
        OP_ST_GTAB: begin st_valid_q <= 1'b1; st_base_q <= tab_base[0]; st_lim_q <= tab_lim[0]; end
        OP_ST_ITAB: begin st_valid_q <= 1'b1; st_base_q <= tab_base[1]; st_lim_q <= tab_lim[1]; end
        OP_ST_LSEL: begin st_valid_q <= 1'b1; st_sel_q <= seg_sel[0]; end
        OP_ST_TSEL: begin st_valid_q <= 1'b1; st_sel_q <= seg_sel[1]; end
        default:    st_valid_q <= 1'b0;
      endcase
    end else if (st_valid_q && st_ready) begin
      st_valid_q <= 1'b0;
    end
  end

  assign st_valid = st_valid_q;
  assign st_base  = st_base_q;
  assign st_limit = st_lim_q;
  assign st_sel   = st_sel_q;

endmodule

// File: rtl/dtr_unit_chk.sv
module dtr_unit_chk #(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ATTR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              st_valid,
  input logic              st_ready,
  input logic [BASE_W-1:0] st_base,
  input logic [LIM_W-1:0]  st_limit,
  input logic [SEL_W-1:0]  st_sel,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [BASE_W-1:0] mem_addr,
  input logic              busy,
  input logic              fault,
  input logic [BASE_W-1:0] gdt_base,
  input logic [SEL_W-1:0]  ldt_sel,
  input logic [SEL_W-1:0]  tr_sel
);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_req_in_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_busy_keeps_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gdt_base));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_store_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_base) && $stable(st_limit) && $stable(st_sel)));

  assert_store_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !cmd_ready);

  assert_fault_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(ldt_sel) && $stable(tr_sel) && !busy));

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

endmodule

bind dtr_unit dtr_unit_chk #(.BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .ATTR_W(ATTR_W)) u_chk (.*);

// File: tb/sim_dtr_unit.sv
module sim_dtr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 32, LW = 16, SW = 16, AW = 8, DW = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [BW-1:0] cmd_base = '0;
  logic [LW-1:0] cmd_limit = '0;
  logic [SW-1:0] cmd_sel = '0, cmd_aux_sel = '0;
  logic [DW-1:0] cmd_desc = '0, cmd_aux_desc = '0;
  logic st_valid, st_ready = 1'b0;
  logic [BW-1:0] st_base;
  logic [LW-1:0] st_limit;
  logic [SW-1:0] st_sel;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [BW-1:0] mem_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic busy, fault;
  logic [BW-1:0] gdt_base, idt_base, ldt_base, tr_base;
  logic [LW-1:0] gdt_limit, idt_limit, ldt_limit, tr_limit;
  logic [SW-1:0] ldt_sel, tr_sel;
  logic [AW-1:0] ldt_attr, tr_attr;
  logic ldt_valid;

  dtr_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, req_cnt = 0;
  bit stall = 1'b0, finished = 1'b0;

  function automatic logic [DW-1:0] mkdesc(input logic [BW-1:0] a);
    return {a[10:3] ^ 8'h5A, a[15:0] ^ 16'h1234, a ^ 32'hC0DE0000};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: answers one cycle after a request is taken
  initial begin
    bit pend = 1'b0;
    logic [BW-1:0] a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mkdesc(a);
        pend = 1'b0;
      end
      mem_req_ready = !stall;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        pend = 1'b1;
        a = mem_addr;
        req_cnt++;
      end
    end
  end

  // drives one command, returns at the negedge after the accepting edge
  task automatic send(input logic [3:0] op, input logic [BW-1:0] b, input logic [LW-1:0] l,
                      input logic [SW-1:0] s, input logic [DW-1:0] d,
                      input logic [SW-1:0] as, input logic [DW-1:0] ad);
    @(negedge clk);
    cmd_op = op; cmd_base = b; cmd_limit = l; cmd_sel = s; cmd_desc = d;
    cmd_aux_sel = as; cmd_aux_desc = ad; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // read-back with two cycles of back-pressure
  task automatic store(input logic [3:0] op, input string req, input logic [BW-1:0] eb,
                       input logic [LW-1:0] el, input logic [SW-1:0] es);
    send(op, '0, '0, '0, '0, '0, '0);
    check({req, " st_valid"}, 64'(st_valid), 64'd1);
    check({req, " st_base"}, 64'(st_base), 64'(eb));
    check({req, " st_limit"}, 64'(st_limit), 64'(el));
    check({req, " st_sel"}, 64'(st_sel), 64'(es));
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check({req, " held st_valid"}, 64'(st_valid), 64'd1);
      check({req, " held st_base"}, 64'(st_base), 64'(eb));
      check({req, " cmd_ready low"}, 64'(cmd_ready), 64'd0);
    end
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
    check({req, " st_valid dropped"}, 64'(st_valid), 64'd0);
    check({req, " cmd_ready back"}, 64'(cmd_ready), 64'd1);
  endtask

  // vectors: {select interrupt table, base, limit}
  localparam logic [48:0] VEC [4] = '{
    {1'b0, 32'h0000_8000, 16'h03FF},
    {1'b1, 32'h0001_0000, 16'h07FF},
    {1'b1, 32'hFFFF_FFF0, 16'h0000},
    {1'b0, 32'h0000_1000, 16'h00FF}
  };

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] sb;
    logic [LW-1:0] sl;
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 gdt_base", 64'(gdt_base), 64'd0);
    check("R1 gdt_limit", 64'(gdt_limit), 64'hFFFF);
    check("R1 idt_base", 64'(idt_base), 64'd0);
    check("R1 idt_limit", 64'(idt_limit), 64'hFFFF);
    check("R1 ldt_sel", 64'(ldt_sel), 64'd0);
    check("R1 ldt_base", 64'(ldt_base), 64'd0);
    check("R1 ldt_limit", 64'(ldt_limit), 64'hFFFF);
    check("R1 ldt_attr", 64'(ldt_attr), 64'd0);
    check("R1 ldt_valid", 64'(ldt_valid), 64'd0);
    check("R1 tr_sel", 64'(tr_sel), 64'd0);
    check("R1 tr_base", 64'(tr_base), 64'd0);
    check("R1 tr_limit", 64'(tr_limit), 64'hFFFF);
    check("R1 tr_attr", 64'(tr_attr), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 fault", 64'(fault), 64'd0);
    check("R1 cmd_ready", 64'(cmd_ready), 64'd1);

    // R2 / R3 table loads and read-backs from the vector table
    for (int i = 0; i < 4; i++) begin
      logic isi;
      isi = VEC[i][48];
      send(isi ? 4'd1 : 4'd0, VEC[i][47:16], VEC[i][15:0], '0, '0, '0, '0);
      check("R2 base", 64'(isi ? idt_base : gdt_base), 64'(VEC[i][47:16]));
      check("R2 limit", 64'(isi ? idt_limit : gdt_limit), 64'(VEC[i][15:0]));
      store(isi ? 4'd3 : 4'd2, "R3 table", VEC[i][47:16], VEC[i][15:0], '0);
    end
    // global now 0x1000 / 0xFF, interrupt 0xFFFFFFF0 / 0

    // R4 R5 R7 local-table fetch with request stall and a refused command
    stall = 1'b1;
    rc = req_cnt;
    send(4'd4, '0, '0, 16'h0028, '0, '0, '0);
    check("R7 busy after load", 64'(busy), 64'd1);
    check("R7 cmd_ready low", 64'(cmd_ready), 64'd0);
    check("R4 mem_req_valid", 64'(mem_req_valid), 64'd1);
    check("R4 mem_addr", 64'(mem_addr), 64'h1028);
    check("R5 ldt_sel old", 64'(ldt_sel), 64'd0);
    cmd_op = 4'd0; cmd_base = 32'hDEAD_0000; cmd_limit = 16'h1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R4 req held", 64'(mem_req_valid), 64'd1);
    check("R4 addr held", 64'(mem_addr), 64'h1028);
    stall = 1'b0;
    @(negedge clk);
    wait_idle();
    check("R4 one request", 64'(req_cnt - rc), 64'd1);
    check("R5 ldt_sel", 64'(ldt_sel), 64'h0028);
    check("R5 ldt_base", 64'(ldt_base), 64'(mkdesc(32'h1028) & 56'hFFFFFFFF));
    check("R5 ldt_limit", 64'(ldt_limit), 64'(32'h1028 ^ 32'h1234) & 64'hFFFF);
    check("R5 ldt_attr", 64'(ldt_attr), 64'(8'h05 ^ 8'h5A));
    check("R5 ldt_valid", 64'(ldt_valid), 64'd1);
    check("R7 refused load no effect", 64'(gdt_base), 64'h1000);
    check("R7 busy cleared", 64'(busy), 64'd0);

    // R4 R5 task fetch at the last slot inside the limit
    send(4'd5, '0, '0, 16'h00FB, '0, '0, '0);
    check("R4 tr addr", 64'(mem_addr), 64'h10F8);
    wait_idle();
    check("R5 tr_sel", 64'(tr_sel), 64'h00FB);
    check("R5 tr_base", 64'(tr_base), 64'hC0DE10F8);
    check("R5 tr_limit", 64'(tr_limit), 64'(16'h10F8 ^ 16'h1234));
    check("R5 tr_attr", 64'(tr_attr), 64'(8'h1F ^ 8'h5A));

    // R6 first slot past the limit
    rc = req_cnt;
    send(4'd5, '0, '0, 16'h0100, '0, '0, '0);
    check("R6 fault high", 64'(fault), 64'd1);
    check("R6 no busy", 64'(busy), 64'd0);
    @(negedge clk);
    check("R6 fault one cycle", 64'(fault), 64'd0);
    check("R6 tr_sel kept", 64'(tr_sel), 64'h00FB);
    check("R6 tr_base kept", 64'(tr_base), 64'hC0DE10F8);
    check("R6 no request", 64'(req_cnt - rc), 64'd0);

    // R8 null local-table selector, even with a tiny table
    send(4'd0, 32'h1000, 16'h0003, '0, '0, '0, '0);
    rc = req_cnt;
    send(4'd4, '0, '0, 16'h0003, '0, '0, '0);
    check("R8 no busy", 64'(busy), 64'd0);
    check("R8 ldt_sel", 64'(ldt_sel), 64'h0003);
    check("R8 ldt_valid", 64'(ldt_valid), 64'd0);
    check("R8 ldt_base kept", 64'(ldt_base), 64'hC0DE1028);
    repeat (3) @(negedge clk);
    check("R8 no request", 64'(req_cnt - rc), 64'd0);
    check("R8 no fault", 64'(fault), 64'd0);

    // R3 selector read-backs
    store(4'd6, "R3 ldt sel", '0, '0, 16'h0003);
    store(4'd7, "R3 tr sel", '0, '0, 16'h00FB);

    // R9 task switch
    rc = req_cnt;
    send(4'd8, '0, '0, 16'h0040, {8'h89, 16'h0067, 32'h0020_0000},
         16'h0048, {8'h82, 16'h00FF, 32'h0030_0000});
    check("R9 tr_sel", 64'(tr_sel), 64'h0040);
    check("R9 tr_base", 64'(tr_base), 64'h0020_0000);
    check("R9 tr_limit", 64'(tr_limit), 64'h0067);
    check("R9 tr_attr", 64'(tr_attr), 64'h89);
    check("R9 ldt_sel", 64'(ldt_sel), 64'h0048);
    check("R9 ldt_base", 64'(ldt_base), 64'h0030_0000);
    check("R9 ldt_limit", 64'(ldt_limit), 64'h00FF);
    check("R9 ldt_attr", 64'(ldt_attr), 64'h82);
    check("R9 ldt_valid", 64'(ldt_valid), 64'd1);
    check("R9 no request", 64'(req_cnt - rc), 64'd0);
    send(4'd8, '0, '0, 16'h0050, '0, 16'h0004, {8'h11, 16'h2222, 32'h3333_3333});
    check("R9 null aux invalid", 64'(ldt_valid), 64'd0);
    check("R9 null aux base", 64'(ldt_base), 64'h3333_3333);

    // R10 undefined op codes
    sb = gdt_base; sl = idt_limit;
    for (int op = 9; op < 16; op++) begin
      send(4'(op), 32'hAAAA_AAAA, 16'h5555, 16'h0FF8, '1, 16'h0FF8, '1);
      check("R10 gdt_base", 64'(gdt_base), 64'(sb));
      check("R10 idt_limit", 64'(idt_limit), 64'(sl));
      check("R10 tr_sel", 64'(tr_sel), 64'h0050);
      check("R10 ldt_sel", 64'(ldt_sel), 64'h0004);
      check("R10 st_valid", 64'(st_valid), 64'd0);
      check("R10 busy", 64'(busy), 64'd0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule